// File: doc/BRIEF.md
# Register Rename Map with Ready Scoreboard

This block translates architectural register numbers into physical register numbers for an out-of-order core, and holds one ready bit per physical register. A single architectural index space carries three classes of register. Integer registers come first, then floating-point registers, then a small set of miscellaneous registers that are never renamed. The physical index space uses the same order: integer physicals, then floating-point physicals, then one fixed slot per miscellaneous register.

A rename request allocates a fresh physical register from the matching external free pool. The pool presents its head register and its occupancy, and the block pulses a pop strobe when it takes the head. The rename returns the new mapping and the mapping it replaced, so the retire logic can later free the old register. In the same cycle the block also serves the following:

- a combinational lookup of any architectural register;
- a combinational ready query of any physical register;
- a writeback port that marks a physical register ready;
- a set-entry port that forces a mapping, used when restoring state.

The free-capacity output tells the rename stage how many renames can be guaranteed from either pool.

Top module: `reg_rename_map`

## Requirements
- R1: Architectural index a is integer when a < N_LINT, floating-point when N_LINT <= a < N_LINT+N_LFP, and miscellaneous otherwise. Lookup of a miscellaneous register returns N_PINT+N_PFP+(a-N_LINT-N_LFP). Lookup of an integer or floating-point register returns its current mapping, combinationally.
- R2: After reset, integer register i maps to physical i, and floating-point register N_LINT+j maps to physical N_PINT+j.
- R3: After reset, the ready bit is 1 for physicals below N_LINT, for physicals N_PINT to N_PINT+N_LFP-1, and for all miscellaneous slots. All other physicals read 0. The ready query is combinational.
- R4: A rename of a non-zero integer or floating-point register returns the current mapping as previous and the head of the matching pool as new. It pulses only that pool's pop strobe, and the mapping takes the new value on the clock edge.
- R5: The physical register allocated by a rename reads not ready from the next cycle.
- R6: A rename of the integer zero register (INT_ZERO) or the floating-point zero register (FP_ZERO) never stalls and pops nothing. It returns the register's current mapping as both new and previous, and changes neither the map nor any ready bit.
- R7: A rename of a miscellaneous register never stalls and pops nothing. It returns its fixed slot as both new and previous, and clears that slot's ready bit.
- R8: ren_ready_o is low when a non-zero integer or floating-point rename finds its pool count at 0. In that case nothing is popped and the map is unchanged.
- R9: Writeback sets the ready bit of the given physical register in any partition, visible from the next cycle.
- R10: When a rename allocates the same physical register that writeback marks in that cycle, the register reads ready afterwards.
- R11: Set-entry overwrites the mapping of an integer or floating-point register. It has no effect on miscellaneous registers or on the two zero registers.
- R12: free_entries_o equals the smaller of the integer and floating-point pool counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ren_valid_i | input | 1 | Rename request |
| ren_arch_i | input | AW | Architectural register to rename |
| ren_ready_o | output | 1 | Rename can complete this cycle |
| ren_new_o | output | PW | New physical mapping |
| ren_prev_o | output | PW | Mapping replaced by the rename |
| int_free_cnt_i | input | CW | Integer pool occupancy |
| int_free_reg_i | input | PW | Integer pool head register |
| int_pop_o | output | 1 | Take integer pool head |
| fp_free_cnt_i | input | CW | Floating-point pool occupancy |
| fp_free_reg_i | input | PW | Floating-point pool head register |
| fp_pop_o | output | 1 | Take floating-point pool head |
| lkp_arch_i | input | AW | Lookup architectural index |
| lkp_phys_o | output | PW | Current mapping of lkp_arch_i |
| qry_phys_i | input | PW | Ready query physical index |
| qry_ready_o | output | 1 | Ready bit of qry_phys_i |
| wb_valid_i | input | 1 | Mark physical register ready |
| wb_phys_i | input | PW | Physical register written back |
| set_valid_i | input | 1 | Force a mapping |
| set_arch_i | input | AW | Architectural register to force |
| set_phys_i | input | PW | Physical register to map it to |
| free_entries_o | output | CW | Smaller of the two pool counts |

## Verification
The bench builds the block with 8 integer and 8 floating-point logical registers, 12 physicals in each pool, and 2 miscellaneous registers. The zero registers are integer 7 and floating-point 15. With these sizes, every architectural lookup and every ready bit can be swept against the reset pattern. Both unmapped physical ranges are small enough to allocate from and to mark ready. The partition boundaries at 8, 16, 12, 24 and 26 all lie within a few indices of registers the bench touches.

// File: rtl/rmap_pkg.sv
package rmap_pkg;
  typedef enum logic [1:0] {
    RC_INT  = 2'd0,
    RC_FP   = 2'd1,
    RC_MISC = 2'd2
  } reg_class_e;
endpackage

// File: rtl/rmap_classify.sv
module rmap_classify
  import rmap_pkg::*;
#(
  parameter int N_LINT   = 32,
  parameter int N_LFP    = 32,
  parameter int AW       = 7,
  parameter int INT_ZERO = 31,
  parameter int FP_ZERO  = 63
) (
  input  logic [AW-1:0] arch_i,
  output reg_class_e    cls_o,
  output logic          zero_o
);
  always_comb begin
    if (32'(arch_i) < N_LINT)              cls_o = RC_INT;
    else if (32'(arch_i) < N_LINT + N_LFP) cls_o = RC_FP;
    else                                   cls_o = RC_MISC;
    zero_o = (cls_o != RC_MISC) &&
             ((32'(arch_i) == INT_ZERO) || (32'(arch_i) == FP_ZERO));
  end
endmodule

// File: rtl/rmap_table.sv
module rmap_table #(
  parameter int N_LREG = 64,
  parameter int N_LINT = 32,
  parameter int N_PINT = 64,
  parameter int AW     = 7,
  parameter int PW     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd0_idx_i,
  output logic [PW-1:0] rd0_o,
  input  logic [AW-1:0] rd1_idx_i,
  output logic [PW-1:0] rd1_o,
  input  logic          wa_valid_i,   // rename write, higher priority
  input  logic [AW-1:0] wa_idx_i,
  input  logic [PW-1:0] wa_data_i,
  input  logic          wb_valid_i,   // set-entry write
  input  logic [AW-1:0] wb_idx_i,
  input  logic [PW-1:0] wb_data_i
);
  localparam int IW = (N_LREG > 1) ? $clog2(N_LREG) : 1;

  logic [PW-1:0] map_w [N_LREG];

  for (genvar i = 0; i < N_LREG; i++) begin : g_ent
    localparam logic [PW-1:0] RST_VAL =
      (i < N_LINT) ? PW'(i) : PW'(N_PINT + i - N_LINT);
    logic [PW-1:0] ent_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 ent_q <= RST_VAL;
      else if (wa_valid_i && wa_idx_i == AW'(i))   ent_q <= wa_data_i;
      else if (wb_valid_i && wb_idx_i == AW'(i))   ent_q <= wb_data_i;
    end
    assign map_w[i] = ent_q;
  end

  assign rd0_o = (32'(rd0_idx_i) < N_LREG) ? map_w[rd0_idx_i[IW-1:0]] : '0;
  assign rd1_o = (32'(rd1_idx_i) < N_LREG) ? map_w[rd1_idx_i[IW-1:0]] : '0;
endmodule

// File: rtl/rmap_scoreboard.sv
module rmap_scoreboard #(
  parameter int N_PTOT  = 132,
  parameter int N_LINT  = 32,
  parameter int N_PINT  = 64,
  parameter int N_LFP   = 32,
  parameter int N_PPHYS = 128,
  parameter int PW      = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_valid_i,
  input  logic [PW-1:0] clr_idx_i,
  input  logic          set_valid_i,
  input  logic [PW-1:0] set_idx_i,
  input  logic [PW-1:0] qry_idx_i,
  output logic          qry_o
);
  logic [N_PTOT-1:0] rdy_q;

  for (genvar i = 0; i < N_PTOT; i++) begin : g_bit
    localparam logic RST_VAL = (i < N_LINT) ||
                               ((i >= N_PINT) && (i < N_PINT + N_LFP)) ||
                               (i >= N_PPHYS);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    rdy_q[i] <= RST_VAL;
      else if (set_valid_i && set_idx_i == PW'(i))    rdy_q[i] <= 1'b1;  // writeback wins
      else if (clr_valid_i && clr_idx_i == PW'(i))    rdy_q[i] <= 1'b0;
    end
  end

  assign qry_o = (32'(qry_idx_i) < N_PTOT) ? rdy_q[qry_idx_i] : 1'b0;
endmodule

// File: rtl/reg_rename_map.sv
module reg_rename_map
  import rmap_pkg::*;
#(
  parameter int N_LINT   = 32,
  parameter int N_LFP    = 32,
  parameter int N_MISC   = 4,
  parameter int N_PINT   = 64,
  parameter int N_PFP    = 64,
  parameter int INT_ZERO = 31,
  parameter int FP_ZERO  = 63,
  localparam int N_LREG  = N_LINT + N_LFP,
  localparam int N_PPHYS = N_PINT + N_PFP,
  localparam int N_PTOT  = N_PPHYS + N_MISC,
  localparam int AW      = $clog2(N_LREG + N_MISC),
  localparam int PW      = $clog2(N_PTOT),
  localparam int CW      = $clog2(((N_PINT > N_PFP) ? N_PINT : N_PFP) + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ren_valid_i,
  input  logic [AW-1:0] ren_arch_i,
  output logic          ren_ready_o,
  output logic [PW-1:0] ren_new_o,
  output logic [PW-1:0] ren_prev_o,
  input  logic [CW-1:0] int_free_cnt_i,
  input  logic [PW-1:0] int_free_reg_i,
  output logic          int_pop_o,
  input  logic [CW-1:0] fp_free_cnt_i,
  input  logic [PW-1:0] fp_free_reg_i,
  output logic          fp_pop_o,
  input  logic [AW-1:0] lkp_arch_i,
  output logic [PW-1:0] lkp_phys_o,
  input  logic [PW-1:0] qry_phys_i,
  output logic          qry_ready_o,
  input  logic          wb_valid_i,
  input  logic [PW-1:0] wb_phys_i,
  input  logic          set_valid_i,
  input  logic [AW-1:0] set_arch_i,
  input  logic [PW-1:0] set_phys_i,
  output logic [CW-1:0] free_entries_o
);
  reg_class_e    ren_cls, set_cls;
  logic          ren_zero, set_zero;
  logic [PW-1:0] cur_map, tbl_lkp;
  logic [PW-1:0] ren_misc_phys, lkp_misc_phys;
  logic          fire, alloc;

  rmap_classify #(.N_LINT(N_LINT), .N_LFP(N_LFP), .AW(AW),
                  .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO)) u_cls_ren (
    .arch_i(ren_arch_i), .cls_o(ren_cls), .zero_o(ren_zero));

  rmap_classify #(.N_LINT(N_LINT), .N_LFP(N_LFP), .AW(AW),
                  .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO)) u_cls_set (
    .arch_i(set_arch_i), .cls_o(set_cls), .zero_o(set_zero));

  assign ren_misc_phys = PW'(N_PPHYS) + PW'(ren_arch_i - AW'(N_LREG));
  assign lkp_misc_phys = PW'(N_PPHYS) + PW'(lkp_arch_i - AW'(N_LREG));

  always_comb begin
    ren_ready_o = 1'b1;
    ren_new_o   = cur_map;
    ren_prev_o  = cur_map;
    alloc       = 1'b0;
    unique case (ren_cls)
      RC_INT: if (!ren_zero) begin
        ren_ready_o = (int_free_cnt_i != '0);
        ren_new_o   = int_free_reg_i;
        alloc       = 1'b1;
      end
      RC_FP: if (!ren_zero) begin
        ren_ready_o = (fp_free_cnt_i != '0);
        ren_new_o   = fp_free_reg_i;
        alloc       = 1'b1;
      end
      default: begin
        ren_new_o  = ren_misc_phys;
        ren_prev_o = ren_misc_phys;
      end
    endcase
  end

  assign fire      = ren_valid_i && ren_ready_o;
  assign int_pop_o = fire && alloc && (ren_cls == RC_INT);
  assign fp_pop_o  = fire && alloc && (ren_cls == RC_FP);

  rmap_table #(.N_LREG(N_LREG), .N_LINT(N_LINT), .N_PINT(N_PINT),
               .AW(AW), .PW(PW)) u_table (
    .clk_i, .rst_ni,
    .rd0_idx_i (ren_arch_i),
    .rd0_o     (cur_map),
    .rd1_idx_i (lkp_arch_i),
    .rd1_o     (tbl_lkp),
    .wa_valid_i(fire && alloc),
    .wa_idx_i  (ren_arch_i),
    .wa_data_i (ren_new_o),
    .wb_valid_i(set_valid_i && (set_cls != RC_MISC) && !set_zero),
    .wb_idx_i  (set_arch_i),
    .wb_data_i (set_phys_i));

  rmap_scoreboard #(.N_PTOT(N_PTOT), .N_LINT(N_LINT), .N_PINT(N_PINT),
                    .N_LFP(N_LFP), .N_PPHYS(N_PPHYS), .PW(PW)) u_sb (
    .clk_i, .rst_ni,
    .clr_valid_i(fire && (alloc || ren_cls == RC_MISC)),
    .clr_idx_i  (ren_new_o),
    .set_valid_i(wb_valid_i),
    .set_idx_i  (wb_phys_i),
    .qry_idx_i  (qry_phys_i),
    .qry_o      (qry_ready_o));

  assign lkp_phys_o = (32'(lkp_arch_i) < N_LREG) ? tbl_lkp : lkp_misc_phys;
  assign free_entries_o = (int_free_cnt_i < fp_free_cnt_i) ? int_free_cnt_i
                                                           : fp_free_cnt_i;
endmodule

// File: rtl/rmap_chk.sv
module rmap_chk #(
  parameter int N_LREG  = 64,
  parameter int N_PPHYS = 128,
  parameter int AW      = 7,
  parameter int PW      = 8,
  parameter int CW      = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          ren_valid_i,
  input logic [AW-1:0] ren_arch_i,
  input logic          ren_ready_o,
  input logic [PW-1:0] ren_new_o,
  input logic [PW-1:0] ren_prev_o,
  input logic [CW-1:0] int_free_cnt_i,
  input logic [PW-1:0] int_free_reg_i,
  input logic          int_pop_o,
  input logic [CW-1:0] fp_free_cnt_i,
  input logic [PW-1:0] fp_free_reg_i,
  input logic          fp_pop_o,
  input logic [PW-1:0] qry_phys_i,
  input logic          qry_ready_o,
  input logic          wb_valid_i,
  input logic [PW-1:0] wb_phys_i,
  input logic [CW-1:0] free_entries_o
);
  // R8
  int_pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_pop_o |-> (int_free_cnt_i != '0));
  // R8
  fp_pop_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_pop_o |-> (fp_free_cnt_i != '0));
  // R4
  single_pool_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(int_pop_o && fp_pop_o));
  // R4
  int_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_pop_o |-> (ren_new_o == int_free_reg_i && ren_valid_i));
  // R4
  fp_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_pop_o |-> (ren_new_o == fp_free_reg_i && ren_valid_i));
  // R7
  misc_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ren_valid_i && 32'(ren_arch_i) >= N_LREG) |->
      (ren_ready_o && ren_new_o == ren_prev_o && 32'(ren_new_o) >= N_PPHYS
       && !int_pop_o && !fp_pop_o));
  // R12
  min_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_entries_o <= int_free_cnt_i && free_entries_o <= fp_free_cnt_i &&
    (free_entries_o == int_free_cnt_i || free_entries_o == fp_free_cnt_i));
  // R9
  wb_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_i |=> (qry_phys_i != $past(wb_phys_i) || qry_ready_o));
endmodule

bind reg_rename_map rmap_chk #(.N_LREG(N_LREG), .N_PPHYS(N_PPHYS),
                               .AW(AW), .PW(PW), .CW(CW)) u_chk (.*);

// File: tb/reg_rename_map_tb.sv
module reg_rename_map_tb;
  localparam int LI = 8, LF = 8, MS = 2, PI = 12, PF = 12;
  localparam int IZ = 7, FZ = 15;
  localparam int NL = LI + LF, NP = PI + PF, NT = NP + MS;
  localparam int AW = $clog2(NL + MS), PW = $clog2(NT);
  localparam int CW = $clog2(((PI > PF) ? PI : PF) + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic          ren_valid = 0, ren_ready;
  logic [AW-1:0] ren_arch = '0, lkp_arch = '0, set_arch = '0;
  logic [PW-1:0] ren_new, ren_prev, int_reg = '0, fp_reg = '0, lkp_phys;
  logic [PW-1:0] qry_phys = '0, wb_phys = '0, set_phys = '0;
  logic [CW-1:0] int_cnt = '0, fp_cnt = '0, free_ent;
  logic          int_pop, fp_pop, qry_rdy, wb_valid = 0, set_valid = 0;

  reg_rename_map #(.N_LINT(LI), .N_LFP(LF), .N_MISC(MS), .N_PINT(PI),
                   .N_PFP(PF), .INT_ZERO(IZ), .FP_ZERO(FZ)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ren_valid_i(ren_valid), .ren_arch_i(ren_arch), .ren_ready_o(ren_ready),
    .ren_new_o(ren_new), .ren_prev_o(ren_prev),
    .int_free_cnt_i(int_cnt), .int_free_reg_i(int_reg), .int_pop_o(int_pop),
    .fp_free_cnt_i(fp_cnt), .fp_free_reg_i(fp_reg), .fp_pop_o(fp_pop),
    .lkp_arch_i(lkp_arch), .lkp_phys_o(lkp_phys),
    .qry_phys_i(qry_phys), .qry_ready_o(qry_rdy),
    .wb_valid_i(wb_valid), .wb_phys_i(wb_phys),
    .set_valid_i(set_valid), .set_arch_i(set_arch), .set_phys_i(set_phys),
    .free_entries_o(free_ent));

  int n_chk = 0, n_fail = 0;
  int mdl_map [NL];
  bit mdl_rdy [NT];
  int exp_new_q[$], exp_prev_q[$];
  string tag_q[$];
  event mon_ev;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // monitor: pops expected rename results and compares
  initial forever begin
    @(mon_ev);
    if (exp_new_q.size() == 0) chk("R4 queue", 1, 0);
    else begin
      automatic string t = tag_q.pop_front();
      chk({t, " new"},  int'(ren_new),  exp_new_q.pop_front());
      chk({t, " prev"}, int'(ren_prev), exp_prev_q.pop_front());
    end
  end

  function automatic int mdl_lookup(input int a);
    if (a < NL) return mdl_map[a];
    return NP + a - NL;
  endfunction

  // driver: one cycle of rename / writeback / set-entry
  task automatic step(input string tag, input bit rv, input int a,
                      input int ir, input int ic, input int fr, input int fc,
                      input bit wv, input int wp,
                      input bit sv, input int sa, input int sp);
    bit zero, is_int, is_fp, rdy, fire;
    int nw, pv;
    @(negedge clk);
    ren_valid = rv; ren_arch = AW'(a);
    int_reg = PW'(ir); int_cnt = CW'(ic); fp_reg = PW'(fr); fp_cnt = CW'(fc);
    wb_valid = wv; wb_phys = PW'(wp);
    set_valid = sv; set_arch = AW'(sa); set_phys = PW'(sp);
    #1;
    is_int = a < LI; is_fp = !is_int && a < NL;
    zero = (is_int || is_fp) && (a == IZ || a == FZ);
    rdy = 1; pv = mdl_lookup(a); nw = pv;
    if (is_int && !zero) begin rdy = ic != 0; nw = ir; end
    if (is_fp  && !zero) begin rdy = fc != 0; nw = fr; end
    fire = rv && rdy;
    chk({tag, " ready"}, int'(ren_ready), int'(rdy));
    chk({tag, " int pop"}, int'(int_pop), int'(fire && is_int && !zero));
    chk({tag, " fp pop"},  int'(fp_pop),  int'(fire && is_fp && !zero));
    chk("R12 free", int'(free_ent), (ic < fc) ? ic : fc);
    if (fire) begin
      exp_new_q.push_back(nw); exp_prev_q.push_back(pv); tag_q.push_back(tag);
      ->mon_ev;
    end
    @(posedge clk);
    if (fire && !zero) begin
      if (a < NL) mdl_map[a] = nw;
      mdl_rdy[nw] = 0;
    end
    if (wv) mdl_rdy[wp] = 1;  // R10: writeback wins
    if (sv && sa < NL && sa != IZ && sa != FZ && !(fire && !zero && sa == a))
      mdl_map[sa] = sp;
    #1;
    ren_valid = 0; wb_valid = 0; set_valid = 0;
  endtask

  task automatic look(input string tag, input int a, input int exp);
    @(negedge clk); lkp_arch = AW'(a); #1;
    chk(tag, int'(lkp_phys), exp);
  endtask

  task automatic query(input string tag, input int p, input int exp);
    @(negedge clk); qry_phys = PW'(p); #1;
    chk(tag, int'(qry_rdy), exp);
  endtask

  initial begin
    #(4 * 200000);
    chk("watchdog", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) mdl_map[i] = (i < LI) ? i : PI + i - LI;
    for (int p = 0; p < NT; p++)
      mdl_rdy[p] = (p < LI) || (p >= PI && p < PI + LF) || (p >= NP);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 R1 reset mapping and misc slots
    for (int a = 0; a < NL + MS; a++) look("R2 R1 reset lookup", a, mdl_lookup(a));
    look("R1 misc slot", 17, 25);
    // R3 reset ready bits
    for (int p = 0; p < NT; p++) query("R3 reset ready", p, int'(mdl_rdy[p]));

    // R4 R5 integer rename
    step("R4 int", 1, 3, 9, 4, 20, 5, 0, 0, 0, 0, 0);
    look("R4 int map", 3, 9);
    query("R5 int not ready", 9, 0);
    // R4 R5 fp rename
    step("R4 fp", 1, 10, 8, 0, 21, 2, 0, 0, 0, 0, 0);
    look("R4 fp map", 10, 21);
    query("R5 fp not ready", 21, 0);
    // R6 zero registers with empty pools
    step("R6 int zero", 1, IZ, 10, 0, 22, 0, 0, 0, 0, 0, 0);
    step("R6 fp zero", 1, FZ, 10, 0, 22, 0, 0, 0, 0, 0, 0);
    look("R6 int zero map", IZ, 7);
    look("R6 fp zero map", FZ, 19);
    query("R6 zero ready kept", 19, 1);
    // R8 stalls
    step("R8 int stall", 1, 2, 10, 0, 22, 3, 0, 0, 0, 0, 0);
    look("R8 int map kept", 2, 2);
    step("R8 fp stall", 1, 12, 10, 3, 22, 0, 0, 0, 0, 0, 0);
    look("R8 fp map kept", 12, 16);
    // R7 misc rename
    step("R7 misc", 1, 17, 10, 0, 22, 0, 0, 0, 0, 0, 0);
    query("R7 misc cleared", 25, 0);
    look("R7 misc lookup", 17, 25);
    // R9 writeback in each partition
    step("R9 wb misc", 0, 0, 0, 1, 0, 1, 1, 25, 0, 0, 0);
    query("R9 misc ready", 25, 1);
    step("R9 wb int", 0, 0, 0, 1, 0, 1, 1, 9, 0, 0, 0);
    query("R9 int ready", 9, 1);
    step("R9 wb fp", 0, 0, 0, 1, 0, 1, 1, 21, 0, 0, 0);
    query("R9 fp ready", 21, 1);
    // R10 same-cycle allocate and writeback
    step("R10 int", 1, 4, 10, 3, 22, 3, 1, 10, 0, 0, 0);
    query("R10 ready wins", 10, 1);
    look("R10 map", 4, 10);
    step("R10 fp", 1, 13, 0, 3, 23, 3, 1, 23, 0, 0, 0);
    query("R10 fp ready wins", 23, 1);
    // R11 set-entry
    step("R11 set int", 0, 0, 0, 1, 0, 1, 0, 0, 1, 5, 11);
    look("R11 int set", 5, 11);
    step("R11 set fp", 0, 0, 0, 1, 0, 1, 0, 0, 1, 9, 22);
    look("R11 fp set", 9, 22);
    step("R11 set misc", 0, 0, 0, 1, 0, 1, 0, 0, 1, 16, 3);
    look("R11 misc ignored", 16, 24);
    step("R11 set zero", 0, 0, 0, 1, 0, 1, 0, 0, 1, IZ, 3);
    look("R11 zero ignored", IZ, 7);
    // R12 min of pools, both orders
    step("R12 a", 0, 0, 0, 7, 0, 2, 0, 0, 0, 0, 0);
    step("R12 b", 0, 0, 0, 12, 0, 12, 0, 0, 0, 0, 0);
    // R4 rename of the renamed register returns its new previous
    step("R4 again", 1, 3, 11, 1, 0, 0, 0, 0, 0, 0, 0);
    look("R4 again map", 3, 11);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule